// File: doc/BRIEF.md
# Constant-Delay Time-Slot Interchanger

This block switches bytes between time-slots of a framed channel stream. One byte arrives per input time-slot and one byte leaves per output time-slot. For each output slot, a connection memory names the input slot whose byte is sent and says whether that output slot is enabled. Every switched byte has the same throughput delay, whatever the two slot numbers are. In time-slots, that delay is N + (N − IN) + (OUT − 1) with 1-based slot numbers: the rest of the input frame, one whole frame, then the slots before the output slot. The data memory holds three frame buffers that rotate at each frame pulse. The current frame writes buffer k, the output reads buffer k−2, and the host reads buffer k−1, which is the last complete frame.

The frame length N follows a 2-bit rate code: 32, 64 or 128 slots. A strobe `slot_tick` marks each slot. On a tick with `frame_pulse` high, that slot is slot 0 of a new frame. A host port writes and reads the connection memory. It can only read the data memory.

A frame-sequencing state machine guards start-up. It has four states:
- `ST_SYNC`: no frame seen.
- `ST_FILL_A`: first frame buffered.
- `ST_FILL_B`: second frame buffered.
- `ST_RUN`: switching.

The machine takes these transitions, each on a tick with the frame pulse:
- `ST_SYNC` to `ST_FILL_A`.
- `ST_FILL_A` to `ST_FILL_B`.
- `ST_FILL_B` to `ST_RUN`.
- `ST_RUN` to `ST_RUN`.

Until `ST_RUN`, every output slot sends 0xFF.

Top module: `cdtsi_switch`

## Requirements
- R1: During and right after reset, `tx_byte` is 0xFF, `host_rdata` is 0, and every connection memory entry reads back as 0 (disabled).
- R2: `rate_sel` sets the frame length N: 00 gives 32 slots, 01 gives 64, and 10 or 11 gives 128. Without a frame pulse, the slot counter wraps from N−1 to 0 and the buffer does not rotate.
- R3: In `ST_RUN`, when an output slot j is enabled with source slot i, its `tx_byte` is the byte received in slot i two frame pulses earlier. `tx_byte` changes only in the clock cycle after a tick.
- R4: In `ST_RUN`, an output slot whose entry has the enable bit clear sends 0xFF.
- R5: `tx_byte` is 0xFF for every slot until the third frame pulse. Each state change happens only on a tick with the frame pulse, and `ST_RUN` is never left except by reset.
- R6: A tick with `frame_pulse` high is slot 0 at any point in a frame, and it rotates the buffers. A short frame is therefore legal. The slot after it is slot 1.
- R7: A host write with `host_addr[7]`=0 stores `host_wdata` into entry `host_addr[6:0]`: bit 7 is the enable and bits 6:0 the source slot. A host read of that address returns the entry in the clock cycle after the request.
- R8: A host read with `host_addr[7]`=1 returns the byte received at slot `host_addr[6:0]` in the last complete frame (buffer k−1).
- R9: A host write with `host_addr[7]`=1 has no effect on the data memory.
- R10: When a host write to entry j lands in the same cycle as the tick of output slot j, that slot uses the old entry. The new entry serves from the next use of slot j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rate_sel | input | 2 | Frame length code |
| slot_tick | input | 1 | One time-slot boundary; rx_byte valid |
| frame_pulse | input | 1 | With slot_tick: this slot is slot 0 of a new frame |
| rx_byte | input | 8 | Received byte of the current input slot |
| tx_byte | output | 8 | Byte sent for the current output slot (registered) |
| host_sel | input | 1 | Host access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Bit 7 selects data memory (1) or connection memory (0); bits 6:0 slot |
| host_wdata | input | 8 | Connection entry to write |
| host_rdata | output | 8 | Read result, valid the cycle after a read |

## Verification
Two functions can fall in the same cycle. A host write to a connection entry can land on the tick that reads that entry for its output slot. A frame pulse can also arrive mid-frame, in the cycle that would otherwise just advance the slot counter. The bench provokes the first by issuing the write together with the tick of that slot. It expects the old entry's byte in that slot and the new entry's byte one frame later. It provokes the second with a short frame and with an over-long frame that wraps without a pulse. A buffer-rotation model computed from the requirements then predicts every output slot and host data read across all three rates.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int NUM_BUFS = 3;

    typedef enum logic [1:0] {
        ST_SYNC   = 2'd0,
        ST_FILL_A = 2'd1,
        ST_FILL_B = 2'd2,
        ST_RUN    = 2'd3
    } tsi_state_e;

    // last slot index for a rate code: 00 -> 31, 01 -> 63, else 127
    function automatic int frame_last(input logic [1:0] rate);
        case (rate)
            2'b00:   return 31;
            2'b01:   return 63;
            default: return 127;
        endcase
    endfunction

    function automatic logic [1:0] ring_next(input logic [1:0] b);
        return (int'(b) == NUM_BUFS - 1) ? 2'd0 : b + 2'd1;
    endfunction

endpackage

// File: rtl/tsi_frame_fsm.sv
module tsi_frame_fsm
    import tsi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot_tick,
    input  logic       frame_pulse,
    output tsi_state_e state_q,
    output tsi_state_e state_live,
    output logic [1:0] wr_buf,
    output logic [1:0] rd_buf,
    output logic [1:0] host_buf
);
    logic [1:0] buf_q;
    logic       new_frame;

    assign new_frame = slot_tick && frame_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SYNC;
            buf_q   <= 2'd0;
        end else if (slot_tick) begin
            state_q <= state_live;
            buf_q   <= wr_buf;
        end
    end

    always_comb begin
        state_live = state_q;
        wr_buf     = buf_q;
        if (new_frame) begin
            wr_buf = ring_next(buf_q);
            unique case (state_q)
                ST_SYNC:   state_live = ST_FILL_A;
                ST_FILL_A: state_live = ST_FILL_B;
                ST_FILL_B: state_live = ST_RUN;
                ST_RUN:    state_live = ST_RUN;
            endcase
        end
        rd_buf   = ring_next(wr_buf);   // k-2
        host_buf = ring_next(rd_buf);   // k-1
    end
endmodule

// File: rtl/tsi_slot_ctr.sv
module tsi_slot_ctr
    import tsi_pkg::*;
#(
    parameter int SLOT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_tick,
    input  logic              frame_pulse,
    input  logic [1:0]        rate_sel,
    output logic [SLOT_W-1:0] cnt_q,
    output logic [SLOT_W-1:0] slot_live
);
    assign slot_live = (slot_tick && frame_pulse) ? '0 : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (slot_tick)
            cnt_q <= (int'(slot_live) >= frame_last(rate_sel)) ? '0 : slot_live + 1'b1;
    end
endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem #(
    parameter int SLOT_W = 7,
    localparam int ENT_W  = SLOT_W + 1,
    localparam int DEPTH  = 1 << SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] waddr,
    input  logic [ENT_W-1:0]  wdata,
    input  logic [SLOT_W-1:0] raddr_a,
    output logic [ENT_W-1:0]  rdata_a,
    input  logic [SLOT_W-1:0] raddr_b,
    output logic [ENT_W-1:0]  rdata_b
);
    logic [ENT_W-1:0] ent_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (we) begin
            ent_q[waddr] <= wdata;
        end
    end

    assign rdata_a = ent_q[raddr_a];
    assign rdata_b = ent_q[raddr_b];
endmodule

// File: rtl/tsi_dmem.sv
module tsi_dmem #(
    parameter int DATA_W = 8,
    parameter int SLOT_W = 7,
    localparam int DEPTH = 1 << SLOT_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [1:0]        wbuf,
    input  logic [SLOT_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        rbuf_a,
    input  logic [SLOT_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [1:0]        rbuf_b,
    input  logic [SLOT_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] mem [tsi_pkg::NUM_BUFS][DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wbuf][waddr] <= wdata;
    end

    assign rdata_a = mem[rbuf_a][raddr_a];
    assign rdata_b = mem[rbuf_b][raddr_b];
endmodule

// File: rtl/cdtsi_switch.sv
module cdtsi_switch
    import tsi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SLOT_W = 7,
    localparam int ENT_W  = SLOT_W + 1,
    localparam int ADDR_W = SLOT_W + 1,
    localparam int HRD_W  = (DATA_W > ENT_W) ? DATA_W : ENT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rate_sel,
    input  logic              slot_tick,
    input  logic              frame_pulse,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [ENT_W-1:0]  host_wdata,
    output logic [HRD_W-1:0]  host_rdata
);
    tsi_state_e        state_q, state_live;
    logic [1:0]        wr_buf, rd_buf, host_buf;
    logic [SLOT_W-1:0] slot_q, slot_live;
    logic [ENT_W-1:0]  ent_out, ent_host;
    logic [DATA_W-1:0] dm_out, dm_host;
    logic              host_dm, cm_we;

    assign host_dm = host_addr[ADDR_W-1];
    assign cm_we   = host_sel && host_wr && !host_dm;

    tsi_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .frame_pulse(frame_pulse),
        .state_q(state_q), .state_live(state_live),
        .wr_buf(wr_buf), .rd_buf(rd_buf), .host_buf(host_buf)
    );

    tsi_slot_ctr #(.SLOT_W(SLOT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .frame_pulse(frame_pulse),
        .rate_sel(rate_sel), .cnt_q(slot_q), .slot_live(slot_live)
    );

    tsi_cmem #(.SLOT_W(SLOT_W)) u_cm (
        .clk(clk), .rst_n(rst_n), .we(cm_we),
        .waddr(host_addr[SLOT_W-1:0]), .wdata(host_wdata),
        .raddr_a(slot_live), .rdata_a(ent_out),
        .raddr_b(host_addr[SLOT_W-1:0]), .rdata_b(ent_host)
    );

    tsi_dmem #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_dm (
        .clk(clk), .we(slot_tick), .wbuf(wr_buf), .waddr(slot_live), .wdata(rx_byte),
        .rbuf_a(rd_buf), .raddr_a(ent_out[SLOT_W-1:0]), .rdata_a(dm_out),
        .rbuf_b(host_buf), .raddr_b(host_addr[SLOT_W-1:0]), .rdata_b(dm_host)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_byte    <= '1;
            host_rdata <= '0;
        end else begin
            if (slot_tick)
                tx_byte <= (state_live == ST_RUN && ent_out[ENT_W-1]) ? dm_out : '1;
            if (host_sel && !host_wr)
                host_rdata <= host_dm ? HRD_W'(dm_host) : HRD_W'(ent_host);
        end
    end
endmodule

// File: rtl/tsi_checker.sv
module tsi_checker
    import tsi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SLOT_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_tick,
    input logic              frame_pulse,
    input logic [1:0]        rate_sel,
    input logic [DATA_W-1:0] tx_byte,
    input logic [SLOT_W-1:0] slot_q,
    input tsi_state_e        state_q
);
    p_fp_slot0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick && frame_pulse |=> slot_q == SLOT_W'(1));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick && !frame_pulse && int'(slot_q) == frame_last(rate_sel) |=> slot_q == '0);

    p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> $stable(tx_byte));

    p_fill_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick && !frame_pulse && state_q != ST_RUN |=> tx_byte == '1);

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != $past(state_q) |-> $past(slot_tick && frame_pulse));

    p_run_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN |=> state_q == ST_RUN);
endmodule

bind cdtsi_switch tsi_checker #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .frame_pulse(frame_pulse),
    .rate_sel(rate_sel), .tx_byte(tx_byte), .slot_q(slot_q), .state_q(state_q)
);

// File: tb/sim_cdtsi_switch.sv
module sim_cdtsi_switch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       slot_tick = 1'b0, frame_pulse = 1'b0;
    logic [7:0] rx_byte = '0, tx_byte;
    logic       host_sel = 1'b0, host_wr = 1'b0;
    logic [7:0] host_addr = '0, host_wdata = '0, host_rdata;

    int n_chk = 0, n_bad = 0;

    // requirement model state
    logic [7:0] mmem [3][128];
    bit         mval [3][128];
    logic [7:0] mcm  [128];
    int mbuf, mcnt, mst, nlen;

    always #4 clk = ~clk;   // 125 MHz

    cdtsi_switch u0 (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .slot_tick(slot_tick),
        .frame_pulse(frame_pulse), .rx_byte(rx_byte), .tx_byte(tx_byte),
        .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] r);
        @(negedge clk);
        rst_n = 1'b0; rate_sel = r;
        nlen = (r == 2'b00) ? 32 : (r == 2'b01) ? 64 : 128;
        mbuf = 0; mcnt = 0; mst = 0;
        for (int b = 0; b < 3; b++)
            for (int s = 0; s < 128; s++) mval[b][s] = 0;
        for (int s = 0; s < 128; s++) mcm[s] = 8'h00;
        repeat (2) @(negedge clk);
        chk("R1 tx in reset", tx_byte, 8'hFF);
        chk("R1 rdata in reset", host_rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tx after reset", tx_byte, 8'hFF);
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
        if (!a[7]) mcm[a[6:0]] = d;
        @(negedge clk);
        host_sel = 0; host_wr = 0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        host_sel = 1; host_wr = 0; host_addr = a;
        @(negedge clk);
        d = host_rdata;
        host_sel = 0;
    endtask

    // one slot; optional host write landing on the same edge
    task automatic tick(input bit fp, input logic [7:0] d, input string tag,
                        input bit hw, input logic [7:0] ha, input logic [7:0] hd);
        logic [7:0] e, exp;
        int slot, rb;
        bit ok;
        string t;
        @(negedge clk);
        slot_tick = 1; frame_pulse = fp; rx_byte = d;
        if (hw) begin host_sel = 1; host_wr = 1; host_addr = ha; host_wdata = hd; end
        if (fp) begin
            if (mst < 3) mst++;
            mbuf = (mbuf + 1) % 3;
            mcnt = 0;
        end
        slot = mcnt;
        rb = (mbuf + 1) % 3;
        e = mcm[slot];
        ok = 1;
        if (mst == 3 && e[7]) begin
            exp = mmem[rb][e[6:0]];
            ok  = mval[rb][e[6:0]];
        end else exp = 8'hFF;
        mmem[mbuf][slot] = d;
        mval[mbuf][slot] = 1;
        mcnt = (slot >= nlen - 1) ? 0 : slot + 1;
        if (hw && !ha[7]) mcm[ha[6:0]] = hd;
        t = (mst != 3) ? "R5 fill" : (!e[7]) ? "R4 disabled" : tag;
        @(negedge clk);
        slot_tick = 0; frame_pulse = 0; host_sel = 0; host_wr = 0;
        if (ok) chk(t, tx_byte, exp);
    endtask

    task automatic run_rate(input logic [1:0] r);
        logic [7:0] rd;
        int lens [7];
        do_reset(r);
        for (int s = 0; s < nlen; s += 9) begin
            hread(8'(s), rd);
            chk("R1 entry cleared", rd, 8'h00);
        end
        for (int j = 0; j < nlen; j++)
            hwrite(8'(j), {(j % 5 != 2), 7'((j * 7 + 3) % nlen)});
        for (int j = 0; j < 4; j++) begin
            hread(8'(j), rd);
            chk("R7 entry readback", rd, mcm[j]);
        end
        lens = '{nlen, nlen, nlen, nlen + 5, 10, nlen, nlen};
        for (int f = 0; f < 7; f++) begin
            for (int s = 0; s < lens[f]; s++) begin
                logic [7:0] d;
                string tg;
                d  = 8'((f * 29 + s * 3 + int'(r) * 11) & 255);
                tg = (f == 3 || f == 5) ? "R2 wrap/R3" : (f == 4 || f == 6) ? "R6 short/R3" : "R3 delay";
                if (f == 4 && s == 6)
                    tick(0, d, "R10 same-cycle old entry", 1, 8'd6, {1'b1, 7'd1});
                else
                    tick(s == 0, d, tg, 0, 8'h00, 8'h00);
                if (s == 0 && f >= 2) begin
                    for (int k = 0; k < 3; k++) begin
                        int a;
                        a = (k == 0) ? 0 : (k == 1) ? 5 : nlen - 1;
                        hread(8'h80 | 8'(a), rd);
                        if (mval[(mbuf + 2) % 3][a])
                            chk("R8 data read", rd, mmem[(mbuf + 2) % 3][a]);
                    end
                end
                if (f == 2 && s == 3) begin
                    hwrite(8'h85, 8'hC3);
                    hread(8'h85, rd);
                    if (mval[(mbuf + 2) % 3][5])
                        chk("R9 write ignored", rd, mmem[(mbuf + 2) % 3][5]);
                end
            end
        end
        hread(8'd6, rd);
        chk("R10 new entry stored", rd, 8'h81);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        run_rate(2'b00);
        run_rate(2'b01);
        run_rate(2'b10);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule